// File: doc/BRIEF.md
# Triple-Buffer Frame Slot Manager

This block keeps the books for three frame buffers that a capture writer and a playback reader share while running at unrelated rates. It records which of the three slots hold finished frames and which slot is the newest. It steers the writer to a fresh slot after each completed frame, always away from the slot the reader is holding. For the reader it picks a slot at each frame start by a fixed priority: a parked slot, then a slot a programmed number of frames behind the newest, then the newest, and if none of those is ready it keeps the slot it already has. The block turns the chosen slot indices into base addresses for the two engines.

An optional lock mode makes playback follow capture: a reader frame start is accepted only after a capture frame has been published since the last accepted start. Bus error responses from either engine set a sticky fault flag, and a capture frame that saw an error is dropped rather than published. Three saturating counters record overwritten unread frames, reads that found nothing ready, and captures that land while the reader is mid-frame under lock mode. No data flows through the block, so every pin is a plain control or status signal: the start, done and error inputs are single-cycle pulses with no handshake. Every state change is registered and appears one clock after the pulse that causes it, and the address outputs follow the slot registers without further delay.

Top module: `tribuf_slot_mgr`

## Requirements
- R1: After reset the write slot and read slot are 0, no slot is valid, the newest slot is 0, the reader is idle, the fault flag is low and all three counters are 0.
- R2: When the store is enabled (configuration bit 0), a write-done pulse on an unfaulted frame marks the write slot valid and newest and moves the writer to the next slot in the order 0, 1, 2, 0; if that slot is the one the reader holds (reader busy, or accepting a start in the same cycle), the writer skips one slot further. Write address = base of the write slot.
- R3: At an accepted read start, if park mode is on (bit 1) and the park slot (bits 3:2) is at most 2 and valid, the reader takes the park slot; a park slot of 3 is ignored.
- R4: Otherwise, with frame delay d (bits 6:5, values 0 to 2, a value of 3 acts as 2), the reader takes the slot d steps behind the newest (modulo 3) when that slot is valid.
- R5: Otherwise the reader takes the newest slot if valid, and if no slot is valid it keeps its current slot. Read address = base of the read slot.
- R6: The read slot is latched only at an accepted start; a start while the reader is busy is ignored, and the slot stays fixed until the read-done pulse.
- R7: With lock mode on (bit 4), a read start is accepted only while the permit output is high; permit rises one cycle after a published capture frame and falls one cycle after an accepted start. With lock mode off, permit is high.
- R8: The overwrite counter increments when a frame is published into a slot that was valid and not started by the reader since it was last published.
- R9: The underrun counter increments when a read start is accepted with the store enabled and no slot valid.
- R10: The sync-loss counter increments when, with lock mode on, a frame is published while the reader is busy.
- R11: A write or read error pulse sets the sticky fault flag. A write error between a write start and its done (or with the done) stops that frame from being published: valid slots, newest and write slot stay unchanged.
- R12: The counters saturate at their all-ones value. A clear pulse zeroes all counters (clear beats a same-cycle event) and the fault flag (a same-cycle error beats clear).
- R13: With the store disabled, both addresses equal base 0, and write-done pulses publish nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 7 | Store enable, park enable, park slot, lock mode, frame delay |
| clear | input | 1 | Zero counters and fault flag |
| base0 | input | ADDR_W | Base address of slot 0 |
| base1 | input | ADDR_W | Base address of slot 1 |
| base2 | input | ADDR_W | Base address of slot 2 |
| wr_start | input | 1 | Capture frame start pulse |
| wr_done | input | 1 | Capture frame done pulse |
| wr_err | input | 1 | Capture bus error pulse |
| rd_start | input | 1 | Playback frame start pulse |
| rd_done | input | 1 | Playback frame done pulse |
| rd_err | input | 1 | Playback bus error pulse |
| wr_addr | output | ADDR_W | Base address for the writer |
| rd_addr | output | ADDR_W | Base address for the reader |
| wr_slot | output | 2 | Current write slot |
| rd_slot | output | 2 | Current read slot |
| valid_slots | output | 3 | One bit per slot holding a finished frame |
| newest_slot | output | 2 | Most recently published slot |
| rd_busy | output | 1 | Reader is inside an accepted frame |
| rd_permit | output | 1 | A read start would be accepted now |
| fault | output | 1 | Sticky error flag |
| cnt_overwrite | output | CNT_W | Overwrite events, saturating |
| cnt_underrun | output | CNT_W | Underrun events, saturating |
| cnt_syncloss | output | CNT_W | Sync-loss events, saturating |

## Verification
A wrong slot register shows up one clock after the pulse that moved it, on the slot outputs and on the matching address, so a reference model stepped every clock pins the cycle of the error. Bad valid or newest bookkeeping is often silent at first and surfaces only at the next accepted read start, when the reader lands on an unexpected slot, or at the next publish, when the overwrite counter moves or fails to. The scenarios therefore follow every write with a read start whose chosen slot depends on the bookkeeping, and run delay, park and lock modes over states where the priority levels disagree.

// File: rtl/tribuf_pkg.sv
package tribuf_pkg;
  localparam int NSLOT = 3;

  typedef logic [1:0] slot_t;

  typedef struct packed {
    logic [1:0] delay;
    logic       lock_en;
    logic [1:0] park_slot;
    logic       park_en;
    logic       store_en;
  } cfg_t;

  function automatic slot_t slot_inc(slot_t s);
    return (s >= slot_t'(NSLOT - 1)) ? slot_t'(0) : s + slot_t'(1);
  endfunction

  function automatic slot_t slot_back(slot_t s, logic [1:0] n);
    slot_t r;
    r = s;
    for (int i = 0; i < 2; i++) begin
      if (i < int'(n)) r = (r == slot_t'(0)) ? slot_t'(NSLOT - 1) : r - slot_t'(1);
    end
    return r;
  endfunction
endpackage

// File: rtl/tribuf_wr_sched.sv
module tribuf_wr_sched
  import tribuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic             wr_start,
  input  logic             wr_done,
  input  logic             wr_err,
  input  logic             hold_vld,
  input  slot_t            hold_slot,
  input  logic             take,
  input  slot_t            take_slot,
  output slot_t            wr_slot,
  output logic [NSLOT-1:0] valid,
  output slot_t            newest,
  output logic             pub,
  output logic             ovw_evt
);
  logic [NSLOT-1:0] seen;
  logic             faulted;
  slot_t            nxt;

  assign pub     = store_en && wr_done && !(faulted || wr_err);
  assign ovw_evt = pub && valid[wr_slot] && !seen[wr_slot];

  always_comb begin
    nxt = slot_inc(wr_slot);
    if (hold_vld && nxt == hold_slot) nxt = slot_inc(nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= '0;
      valid   <= '0;
      seen    <= '0;
      newest  <= '0;
      faulted <= 1'b0;
    end else begin
      if (wr_err)                    faulted <= 1'b1;
      else if (wr_start || wr_done)  faulted <= 1'b0;
      if (take && valid[take_slot])  seen[take_slot] <= 1'b1;
      if (pub) begin
        valid[wr_slot] <= 1'b1;
        seen[wr_slot]  <= 1'b0;
        newest         <= wr_slot;
        wr_slot        <= nxt;
      end
    end
  end
endmodule

// File: rtl/tribuf_rd_select.sv
module tribuf_rd_select
  import tribuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [NSLOT-1:0] valid,
  input  slot_t            newest,
  input  logic             rd_start,
  input  logic             rd_done,
  input  logic             pub,
  output slot_t            rd_slot,
  output logic             rd_busy,
  output logic             permit,
  output slot_t            cand,
  output logic             accept,
  output logic             und_evt,
  output logic             sl_evt
);
  logic       token;
  logic [1:0] dl;
  slot_t      behind;

  assign dl      = (cfg.delay == 2'd3) ? 2'd2 : cfg.delay;
  assign behind  = slot_back(newest, dl);
  assign permit  = !cfg.lock_en || token;
  assign accept  = rd_start && !rd_busy && permit;
  assign und_evt = accept && cfg.store_en && (valid == '0);
  assign sl_evt  = cfg.lock_en && pub && rd_busy;

  always_comb begin
    if (cfg.park_en && cfg.park_slot <= slot_t'(NSLOT - 1) && valid[cfg.park_slot])
      cand = cfg.park_slot;
    else if (valid[behind])
      cand = behind;
    else if (valid[newest])
      cand = newest;
    else
      cand = rd_slot;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_slot <= '0;
      rd_busy <= 1'b0;
      token   <= 1'b0;
    end else begin
      if (pub)         token <= 1'b1;
      else if (accept) token <= 1'b0;
      if (accept)       rd_busy <= 1'b1;
      else if (rd_done) rd_busy <= 1'b0;
      if (accept && cfg.store_en) rd_slot <= cand;
    end
  end
endmodule

// File: rtl/tribuf_evt_cnt.sv
module tribuf_evt_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         evt,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clear)             cnt <= '0;
    else if (evt && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tribuf_slot_mgr.sv
module tribuf_slot_mgr
  import tribuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        cfg_word,
  input  logic              clear,
  input  logic [ADDR_W-1:0] base0,
  input  logic [ADDR_W-1:0] base1,
  input  logic [ADDR_W-1:0] base2,
  input  logic              wr_start,
  input  logic              wr_done,
  input  logic              wr_err,
  input  logic              rd_start,
  input  logic              rd_done,
  input  logic              rd_err,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        wr_slot,
  output logic [1:0]        rd_slot,
  output logic [2:0]        valid_slots,
  output logic [1:0]        newest_slot,
  output logic              rd_busy,
  output logic              rd_permit,
  output logic              fault,
  output logic [CNT_W-1:0]  cnt_overwrite,
  output logic [CNT_W-1:0]  cnt_underrun,
  output logic [CNT_W-1:0]  cnt_syncloss
);
  localparam int NEVT = 3;

  cfg_t  cfg;
  slot_t cand, hold_slot;
  logic  pub, accept, hold_vld, ovw_evt, und_evt, sl_evt;
  logic [NEVT-1:0]  evts;
  logic [CNT_W-1:0] cnts [NEVT];

  assign cfg       = cfg_t'(cfg_word);
  assign hold_vld  = rd_busy || (accept && cfg.store_en);
  assign hold_slot = rd_busy ? rd_slot : cand;

  tribuf_wr_sched u_wr (
    .clk(clk), .rst_n(rst_n), .store_en(cfg.store_en),
    .wr_start(wr_start), .wr_done(wr_done), .wr_err(wr_err),
    .hold_vld(hold_vld), .hold_slot(hold_slot),
    .take(accept && cfg.store_en), .take_slot(cand),
    .wr_slot(wr_slot), .valid(valid_slots), .newest(newest_slot),
    .pub(pub), .ovw_evt(ovw_evt)
  );

  tribuf_rd_select u_rd (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .valid(valid_slots),
    .newest(newest_slot), .rd_start(rd_start), .rd_done(rd_done), .pub(pub),
    .rd_slot(rd_slot), .rd_busy(rd_busy), .permit(rd_permit), .cand(cand),
    .accept(accept), .und_evt(und_evt), .sl_evt(sl_evt)
  );

  assign evts = {sl_evt, und_evt, ovw_evt};

  for (genvar g = 0; g < NEVT; g++) begin : g_cnt
    tribuf_evt_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(clear), .evt(evts[g]), .cnt(cnts[g])
    );
  end

  assign cnt_overwrite = cnts[0];
  assign cnt_underrun  = cnts[1];
  assign cnt_syncloss  = cnts[2];

  always_ff @(posedge clk) begin
    if (!rst_n)                fault <= 1'b0;
    else if (wr_err || rd_err) fault <= 1'b1;
    else if (clear)            fault <= 1'b0;
  end

  function automatic logic [ADDR_W-1:0] pick(slot_t s);
    case (s)
      2'd1:    return base1;
      2'd2:    return base2;
      default: return base0;
    endcase
  endfunction

  assign wr_addr = cfg.store_en ? pick(wr_slot) : base0;
  assign rd_addr = cfg.store_en ? pick(rd_slot) : base0;
endmodule

// File: rtl/tribuf_slot_mgr_chk.sv
module tribuf_slot_mgr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             lock_en,
  input logic             pub,
  input logic             wr_done,
  input logic             wr_err,
  input logic             rd_start,
  input logic             rd_done,
  input logic             rd_busy,
  input logic             rd_permit,
  input logic [1:0]       rd_slot,
  input logic [1:0]       wr_slot,
  input logic [2:0]       valid_slots,
  input logic             fault,
  input logic [CNT_W-1:0] cnt_overwrite,
  input logic [CNT_W-1:0] cnt_underrun,
  input logic [CNT_W-1:0] cnt_syncloss
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_rd_slot_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && !rd_done) |=> $stable(rd_slot));

  assert_writer_avoids_reader_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pub && rd_busy && !rd_done) |=> (wr_slot != rd_slot));

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clear) |=> fault);

  assert_faulted_frame_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wr_err) |=> ($stable(valid_slots) && $stable(wr_slot)));

  assert_overwrite_saturates_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_overwrite == TOP && !clear) |=> (cnt_overwrite == TOP));

  assert_clear_zeroes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_overwrite == '0 && cnt_underrun == '0 && cnt_syncloss == '0));

  assert_lock_blocks_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && !rd_permit && rd_start && !rd_busy) |=> !rd_busy);
endmodule

bind tribuf_slot_mgr tribuf_slot_mgr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .lock_en(cfg_word[4]), .pub(pub),
  .wr_done(wr_done), .wr_err(wr_err), .rd_start(rd_start), .rd_done(rd_done),
  .rd_busy(rd_busy), .rd_permit(rd_permit), .rd_slot(rd_slot), .wr_slot(wr_slot),
  .valid_slots(valid_slots), .fault(fault), .cnt_overwrite(cnt_overwrite),
  .cnt_underrun(cnt_underrun), .cnt_syncloss(cnt_syncloss)
);

// File: tb/tribuf_slot_mgr_bench.sv
module tribuf_slot_mgr_bench;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int CMAX = 15;
  localparam logic [AW-1:0] B0 = 32'h1000_0000;
  localparam logic [AW-1:0] B1 = 32'h1010_0000;
  localparam logic [AW-1:0] B2 = 32'h1020_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cfg = '0;
  logic clear = 0, i_ws = 0, i_wd = 0, i_we = 0, i_rs = 0, i_rd = 0, i_re = 0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [1:0] wr_slot, rd_slot, newest_slot;
  logic [2:0] valid_slots;
  logic rd_busy, rd_permit, fault;
  logic [CW-1:0] cnt_overwrite, cnt_underrun, cnt_syncloss;

  int checks = 0;
  int fails = 0;

  int m_wr, m_rd, m_new, m_busy, m_tok, m_wf, m_fault, m_ow, m_ur, m_sl;
  int m_valid[3];
  int m_seen[3];

  always #2 clk = ~clk;

  tribuf_slot_mgr #(.ADDR_W(AW), .CNT_W(CW)) u_tribuf_slot_mgr (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg), .clear(clear),
    .base0(B0), .base1(B1), .base2(B2),
    .wr_start(i_ws), .wr_done(i_wd), .wr_err(i_we),
    .rd_start(i_rs), .rd_done(i_rd), .rd_err(i_re),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_slot(wr_slot), .rd_slot(rd_slot),
    .valid_slots(valid_slots), .newest_slot(newest_slot), .rd_busy(rd_busy),
    .rd_permit(rd_permit), .fault(fault), .cnt_overwrite(cnt_overwrite),
    .cnt_underrun(cnt_underrun), .cnt_syncloss(cnt_syncloss)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] base_of(int s);
    return (s == 1) ? B1 : (s == 2) ? B2 : B0;
  endfunction

  function automatic int sat_inc(int c, int ev, int cl);
    if (cl) return 0;
    if (ev && c < CMAX) return c + 1;
    return c;
  endfunction

  task automatic model_reset();
    m_wr = 0; m_rd = 0; m_new = 0; m_busy = 0; m_tok = 0; m_wf = 0;
    m_fault = 0; m_ow = 0; m_ur = 0; m_sl = 0;
    for (int i = 0; i < 3; i++) begin m_valid[i] = 0; m_seen[i] = 0; end
  endtask

  task automatic compare_all();
    int se;
    se = cfg[0];
    chk("R2", "wr_slot", wr_slot, m_wr);
    chk("R2", "wr_addr", wr_addr, se ? base_of(m_wr) : B0);
    chk("R2", "valid_slots", valid_slots, m_valid[0] + 2 * m_valid[1] + 4 * m_valid[2]);
    chk("R2", "newest_slot", newest_slot, m_new);
    chk("R6", "rd_slot", rd_slot, m_rd);
    chk("R5", "rd_addr", rd_addr, se ? base_of(m_rd) : B0);
    chk("R6", "rd_busy", rd_busy, m_busy);
    chk("R7", "rd_permit", rd_permit, (!cfg[4]) || m_tok);
    chk("R11", "fault", fault, m_fault);
    chk("R8", "cnt_overwrite", cnt_overwrite, m_ow);
    chk("R9", "cnt_underrun", cnt_underrun, m_ur);
    chk("R10", "cnt_syncloss", cnt_syncloss, m_sl);
  endtask

  task automatic step(input bit ws, input bit wd, input bit we, input bit rs,
                      input bit rd, input bit re, input bit cl);
    int se, pe, ps, gl, d, anyv, permit, dly, cand, acc, pub, hold, hs, n, ovw, und, sl, ow;
    i_ws = ws; i_wd = wd; i_we = we; i_rs = rs; i_rd = rd; i_re = re; clear = cl;
    se = cfg[0]; pe = cfg[1]; ps = cfg[3:2]; gl = cfg[4]; d = cfg[6:5];
    if (d > 2) d = 2;
    anyv = m_valid[0] | m_valid[1] | m_valid[2];
    permit = (!gl) || m_tok;
    dly = (m_new - d + 3) % 3;
    if (pe && ps <= 2 && m_valid[ps]) cand = ps;
    else if (m_valid[dly])            cand = dly;
    else if (m_valid[m_new])          cand = m_new;
    else                              cand = m_rd;
    acc  = rs && !m_busy && permit;
    pub  = se && wd && !(m_wf || we);
    hold = m_busy || (acc && se);
    hs   = m_busy ? m_rd : cand;
    ow   = m_wr;
    ovw  = pub && m_valid[ow] && !m_seen[ow];
    und  = acc && se && !anyv;
    sl   = gl && pub && m_busy;
    @(negedge clk);
    if (acc && se && m_valid[cand]) m_seen[cand] = 1;
    if (pub) begin
      m_valid[ow] = 1; m_seen[ow] = 0; m_new = ow;
      n = (ow + 1) % 3;
      if (hold && n == hs) n = (n + 1) % 3;
      m_wr = n;
    end
    m_wf = we ? 1 : ((ws || wd) ? 0 : m_wf);
    m_tok = pub ? 1 : (acc ? 0 : m_tok);
    if (acc && se) m_rd = cand;
    m_busy = acc ? 1 : (rd ? 0 : m_busy);
    m_fault = (we || re) ? 1 : (cl ? 0 : m_fault);
    m_ow = sat_inc(m_ow, ovw, cl);
    m_ur = sat_inc(m_ur, und, cl);
    m_sl = sat_inc(m_sl, sl, cl);
    compare_all();
  endtask

  task automatic idle();            step(0,0,0,0,0,0,0); endtask
  task automatic rstart();          step(0,0,0,1,0,0,0); endtask
  task automatic rdone();           step(0,0,0,0,1,0,0); endtask
  task automatic wframe();
    step(1,0,0,0,0,0,0); idle(); step(0,1,0,0,0,0,0);
  endtask

  function automatic logic [6:0] mkcfg(int en, int pk, int ps, int gl, int d);
    return {2'(d), 1'(gl), 2'(ps), 1'(pk), 1'(en)};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "wr_slot", wr_slot, 0);
    chk("R1", "rd_slot", rd_slot, 0);
    chk("R1", "valid_slots", valid_slots, 0);
    chk("R1", "fault", fault, 0);
    chk("R1", "counters", cnt_overwrite + cnt_underrun + cnt_syncloss, 0);
    chk("R1", "rd_busy", rd_busy, 0);

    cfg = mkcfg(1, 0, 0, 0, 0);
    rstart(); rdone();
    chk("R9", "underrun after empty read", cnt_underrun, 1);

    wframe();
    chk("R2", "slot0 published", valid_slots, 3'b001);
    chk("R2", "writer moved", wr_slot, 1);
    rstart();
    chk("R5", "reader takes newest", rd_slot, 0);
    wframe(); wframe();
    chk("R2", "writer skips held slot", wr_slot, 1);
    rstart();
    chk("R6", "start while busy ignored", rd_slot, 0);
    rdone();
    wframe();
    chk("R8", "overwrite of unread slot", cnt_overwrite, 1);

    cfg = mkcfg(1, 0, 0, 0, 1);
    rstart(); chk("R4", "delay one", rd_slot, 0); rdone();
    cfg = mkcfg(1, 0, 0, 0, 2);
    rstart(); chk("R4", "delay two", rd_slot, 2); rdone();
    cfg = mkcfg(1, 1, 2, 0, 0);
    rstart(); chk("R3", "park slot 2", rd_slot, 2); rdone();
    cfg = mkcfg(1, 1, 3, 0, 0);
    rstart(); chk("R3", "park slot 3 ignored", rd_slot, 1); rdone();

    cfg = mkcfg(1, 0, 0, 1, 0);
    idle();
    rstart();
    chk("R7", "start refused without capture", rd_busy, 0);
    wframe();
    chk("R7", "permit after capture", rd_permit, 1);
    rstart();
    chk("R7", "start accepted", rd_busy, 1);
    chk("R7", "permit consumed", rd_permit, 0);
    wframe();
    chk("R10", "sync-loss while reading", cnt_syncloss, 1);
    rdone();

    cfg = mkcfg(1, 0, 0, 0, 0);
    step(1,0,0,0,0,0,0); step(0,0,1,0,0,0,0); step(0,1,0,0,0,0,0);
    chk("R11", "fault set", fault, 1);
    chk("R11", "faulted frame not published", wr_slot, 1);
    step(0,0,0,0,0,1,0);
    chk("R11", "fault sticky", fault, 1);
    step(0,0,0,0,0,0,1);
    chk("R12", "clear fault", fault, 0);
    chk("R12", "clear counters", cnt_overwrite + cnt_underrun + cnt_syncloss, 0);

    for (int k = 0; k < 20; k++) wframe();
    chk("R12", "overwrite saturates", cnt_overwrite, CMAX);

    cfg = mkcfg(0, 0, 0, 0, 0);
    idle();
    chk("R13", "write addr base0", wr_addr, B0);
    chk("R13", "read addr base0", rd_addr, B0);
    wframe();
    chk("R13", "no publish while disabled", newest_slot, m_new);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule